// File: doc/BRIEF.md
# Video Reference Sequence Timing Extractor

This block watches a parallel digital video stream, one word per pixel clock. It finds the timing reference sequences that mark the end and start of active video on every line and decodes their status word. From these it rebuilds horizontal, vertical and field timing. The stream can arrive in one of two forms. In the wide form, luma and chroma come on separate 10-bit buses and a sequence takes four clocks. In the multiplexed form, a single bus carries every word twice and a sequence takes eight clocks.

The video words leave the block on a fixed delay. This lets the horizontal strobe rise on the first word of a sequence, even though that sequence can only be recognised on its last word. An input selects the horizontal strobe style. One style marks the whole blanking interval. The other marks only the reference words. Timing outputs are released only after the block has seen a full frame of consistent lines. They drop the moment an expected end-of-active-video sequence fails to arrive.

The status word carries a fixed 1 in bit 9, the field flag F in bit 8, the vertical flag V in bit 7, and the end/start flag H in bit 6 (1 = end of active video, 0 = start). Bits 1:0 are zero. The remaining bits are not checked.

Top module: `vid_trs_timing`

## Requirements
- R1: With `wide_i`=1, a sequence is found when the luma bus carries 3FF, 000, 000 and then a status word with bit 9 = 1 and bits 1:0 = 0. `eav_o` (bit 6 = 1) or `sav_o` (bit 6 = 0) then pulses for one cycle, aligned with that status word at `luma_o`. The two pulses are never high together, and they appear whether or not lock is held.
- R2: With `wide_i`=1, a sequence is rejected unless the chroma bus carries the same 3FF, 000, 000 words and a status word identical to the luma one.
- R3: With `wide_i`=0, a sequence is found on the luma bus as 3FF, 3FF, 000 ×4 and then two identical status words. The pulse is aligned with the second status word. `chroma_i` is ignored for detection.
- R4: With `wide_i`=0, a sequence whose two status copies differ, or whose 3FF is not doubled, produces no pulse.
- R5: `luma_o` and `chroma_o` repeat the inputs 9 clock cycles later. All timing outputs are aligned with these delayed words.
- R6: With `h_ref_mode_i`=0, `h_o` is high from the first word of an end-of-active sequence through the last word of the following start-of-active sequence.
- R7: With `h_ref_mode_i`=1, `h_o` is high only on the words of either sequence, including both status words.
- R8: `v_o` and `f_o` take bits 7 and 8 of each end-of-active status word, on that word, and hold until the next one.
- R9: A frame start is an end-of-active status word with V=1 and F=0 whose preceding end-of-active word had V=0. Every line must have the same clock count. `locked_o` rises on the cycle after the status word of the second frame start after reset is captured at the input, and not before.
- R10: While locked, a missing end-of-active sequence (none by the line length), a line of the wrong length, or a frame of the wrong line count clears `locked_o`. Clearing `locked_o` also forces `h_o`, `v_o` and `f_o` low in the same cycle.
- R11: During reset, and whenever `locked_o` is low, `h_o`, `v_o` and `f_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wide_i | input | 1 | 1: separate luma/chroma buses, 0: multiplexed single bus |
| h_ref_mode_i | input | 1 | 0: blanking-interval H, 1: reference-word H |
| luma_i | input | 10 | Luma or multiplexed video word |
| chroma_i | input | 10 | Chroma word (wide form only) |
| luma_o | output | 10 | Delayed luma word |
| chroma_o | output | 10 | Delayed chroma word |
| h_o | output | 1 | Horizontal timing strobe |
| v_o | output | 1 | Vertical blanking flag |
| f_o | output | 1 | Field flag |
| eav_o | output | 1 | End-of-active status word pulse |
| sav_o | output | 1 | Start-of-active status word pulse |
| locked_o | output | 1 | Timing lock |

## Verification
Full interlaced-style frames are played in three runs: wide with blanking H, wide with reference H, and multiplexed with blanking H. Each run includes two field values and two vertical blanking regions. This separates correct V/F tracking from a block that only follows V, and tells the two H styles apart on the same line. Short hand-built sequences with a mismatched chroma word, a differing status copy or a single 3FF show that the acceptance rules are enforced. Meanwhile a constant 3FF on the chroma bus in multiplexed form shows that this bus takes no part there. Stopping the stream inside vertical blanking while lock is held gives the exact cycle at which lock and all strobes must fall together.

// File: rtl/vid_trs_pkg.sv
package vid_trs_pkg;
  localparam int unsigned WORD_W   = 10;
  localparam int unsigned SEQ_WIDE = 4;
  localparam int unsigned SEQ_MUX  = 8;
  localparam int unsigned XYZ_F    = WORD_W - 2;
  localparam int unsigned XYZ_V    = WORD_W - 3;
  localparam int unsigned XYZ_H    = WORD_W - 4;

  typedef struct packed {
    logic [WORD_W-1:0] y;
    logic [WORD_W-1:0] c;
    logic              trs;
    logic              eav;
    logic              last;
    logic              v;
    logic              f;
  } tap_t;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_LINE,
    ST_SYNC,
    ST_FRAME,
    ST_LOCK
  } lock_st_e;
endpackage

// File: rtl/vid_trs_detect.sv
module vid_trs_detect
  import vid_trs_pkg::*;
#(
  parameter int unsigned DEPTH = SEQ_MUX
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_i,
  input  logic [WORD_W-1:0] y_i,
  input  logic [WORD_W-1:0] c_i,
  output logic              det_o,
  output logic              h_o,
  output logic              v_o,
  output logic              f_o,
  output tap_t              tail_o
);
  tap_t dl_q [DEPTH];
  logic det_wide, det_mux, det;
  int   nmark;

  function automatic logic xyz_ok(input logic [WORD_W-1:0] w);
    return w[WORD_W-1] & ~|w[1:0];
  endfunction

  always_comb begin
    det_wide = xyz_ok(y_i) & (c_i == y_i);
    for (int i = 0; i <= int'(SEQ_WIDE) - 3; i++)
      det_wide &= ~|dl_q[i].y & ~|dl_q[i].c;
    det_wide &= (&dl_q[SEQ_WIDE-2].y) & (&dl_q[SEQ_WIDE-2].c);

    det_mux = xyz_ok(y_i) & (dl_q[0].y == y_i);
    for (int i = 1; i <= int'(SEQ_MUX) - 4; i++)
      det_mux &= ~|dl_q[i].y;
    for (int i = int'(SEQ_MUX) - 3; i <= int'(SEQ_MUX) - 2; i++)
      det_mux &= &dl_q[i].y;

    det   = wide_i ? det_wide : det_mux;
    nmark = wide_i ? int'(SEQ_WIDE) : int'(SEQ_MUX);
  end

  // tag the whole sequence retroactively while it is still in the delay line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) dl_q[i] <= '0;
    end else begin
      dl_q[0].y    <= y_i;
      dl_q[0].c    <= c_i;
      dl_q[0].trs  <= det;
      dl_q[0].eav  <= det & y_i[XYZ_H];
      dl_q[0].last <= det;
      dl_q[0].v    <= det & y_i[XYZ_V];
      dl_q[0].f    <= det & y_i[XYZ_F];
      for (int i = 1; i < int'(DEPTH); i++) begin
        dl_q[i] <= dl_q[i-1];
        if (det && i < nmark) begin
          dl_q[i].trs <= 1'b1;
          dl_q[i].eav <= y_i[XYZ_H];
          dl_q[i].v   <= y_i[XYZ_V];
          dl_q[i].f   <= y_i[XYZ_F];
        end
      end
    end
  end

  assign det_o  = det;
  assign h_o    = y_i[XYZ_H];
  assign v_o    = y_i[XYZ_V];
  assign f_o    = y_i[XYZ_F];
  assign tail_o = dl_q[DEPTH-1];
endmodule

// File: rtl/vid_trs_lock.sv
module vid_trs_lock
  import vid_trs_pkg::*;
#(
  parameter int unsigned LINE_CW  = 16,
  parameter int unsigned FRAME_CW = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic det_i,
  input  logic h_i,
  input  logic v_i,
  input  logic f_i,
  output logic lock_nxt_o
);
  lock_st_e             st_q, st_d;
  logic [LINE_CW-1:0]   wcnt_q, len_q;
  logic [FRAME_CW-1:0]  lcnt_q, lcnt_d, flines_q;
  logic                 v_prev_q, len_ld, fl_ld;
  logic                 eav, fstart, len_ok, expire;

  assign eav    = det_i & h_i;
  assign fstart = eav & v_i & ~v_prev_q & ~f_i;
  assign len_ok = (wcnt_q == len_q);
  assign expire = ~eav & len_ok;

  always_comb begin
    st_d   = st_q;
    lcnt_d = lcnt_q;
    len_ld = 1'b0;
    fl_ld  = 1'b0;
    unique case (st_q)
      ST_HUNT: if (eav) st_d = ST_LINE;
      ST_LINE: if (eav) begin
        st_d   = ST_SYNC;
        len_ld = 1'b1;
      end
      default: begin
        if (eav && !len_ok) st_d = ST_LINE;
        else if (expire) st_d = ST_HUNT;
        else if (eav) begin
          if (st_q == ST_SYNC) begin
            if (fstart) begin
              st_d   = ST_FRAME;
              lcnt_d = FRAME_CW'(1);
            end
          end else if (st_q == ST_FRAME) begin
            if (fstart) begin
              st_d   = ST_LOCK;
              fl_ld  = 1'b1;
              lcnt_d = FRAME_CW'(1);
            end else if (&lcnt_q) st_d = ST_HUNT;
            else lcnt_d = lcnt_q + 1'b1;
          end else begin
            // frame start must coincide with the learned line count
            if (fstart != (lcnt_q == flines_q)) st_d = ST_LINE;
            else if (fstart) lcnt_d = FRAME_CW'(1);
            else lcnt_d = lcnt_q + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_HUNT;
      wcnt_q   <= '0;
      len_q    <= '0;
      lcnt_q   <= '0;
      flines_q <= '0;
      v_prev_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      lcnt_q <= lcnt_d;
      if (eav) wcnt_q <= '0;
      else if (!(&wcnt_q)) wcnt_q <= wcnt_q + 1'b1;
      if (len_ld) len_q <= wcnt_q;
      if (fl_ld) flines_q <= lcnt_q;
      if (eav) v_prev_q <= v_i;
    end
  end

  assign lock_nxt_o = (st_d == ST_LOCK);
endmodule

// File: rtl/vid_trs_timing_out.sv
module vid_trs_timing_out
  import vid_trs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_mode_i,
  input  logic              lock_i,
  input  tap_t              tail_i,
  output logic [WORD_W-1:0] y_o,
  output logic [WORD_W-1:0] c_o,
  output logic              h_o,
  output logic              v_o,
  output logic              f_o,
  output logic              eav_o,
  output logic              sav_o,
  output logic              locked_o
);
  logic blank_q, v_hold_q, f_hold_q;
  logic eav_word, eav_xyz, sav_xyz, h_raw, v_raw, f_raw;

  assign eav_word = tail_i.trs & tail_i.eav;
  assign eav_xyz  = tail_i.last & tail_i.eav;
  assign sav_xyz  = tail_i.last & ~tail_i.eav;
  assign h_raw    = ref_mode_i ? tail_i.trs : (eav_word | blank_q);
  assign v_raw    = eav_xyz ? tail_i.v : v_hold_q;
  assign f_raw    = eav_xyz ? tail_i.f : f_hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blank_q  <= 1'b0;
      v_hold_q <= 1'b0;
      f_hold_q <= 1'b0;
      y_o      <= '0;
      c_o      <= '0;
      h_o      <= 1'b0;
      v_o      <= 1'b0;
      f_o      <= 1'b0;
      eav_o    <= 1'b0;
      sav_o    <= 1'b0;
      locked_o <= 1'b0;
    end else begin
      if (eav_word) blank_q <= 1'b1;
      else if (sav_xyz) blank_q <= 1'b0;
      v_hold_q <= v_raw;
      f_hold_q <= f_raw;
      y_o      <= tail_i.y;
      c_o      <= tail_i.c;
      eav_o    <= eav_xyz;
      sav_o    <= sav_xyz;
      locked_o <= lock_i;
      h_o      <= lock_i & h_raw;
      v_o      <= lock_i & v_raw;
      f_o      <= lock_i & f_raw;
    end
  end
endmodule

// File: rtl/vid_trs_timing.sv
module vid_trs_timing
  import vid_trs_pkg::*;
#(
  parameter int unsigned LINE_CW  = 16,
  parameter int unsigned FRAME_CW = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_i,
  input  logic              h_ref_mode_i,
  input  logic [WORD_W-1:0] luma_i,
  input  logic [WORD_W-1:0] chroma_i,
  output logic [WORD_W-1:0] luma_o,
  output logic [WORD_W-1:0] chroma_o,
  output logic              h_o,
  output logic              v_o,
  output logic              f_o,
  output logic              eav_o,
  output logic              sav_o,
  output logic              locked_o
);
  localparam int unsigned DEPTH = (SEQ_MUX > SEQ_WIDE) ? SEQ_MUX : SEQ_WIDE;

  tap_t tail;
  logic det, det_h, det_v, det_f, lock_nxt;

  vid_trs_detect #(.DEPTH(DEPTH)) u_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wide_i (wide_i),
    .y_i    (luma_i),
    .c_i    (chroma_i),
    .det_o  (det),
    .h_o    (det_h),
    .v_o    (det_v),
    .f_o    (det_f),
    .tail_o (tail)
  );

  vid_trs_lock #(.LINE_CW(LINE_CW), .FRAME_CW(FRAME_CW)) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .det_i      (det),
    .h_i        (det_h),
    .v_i        (det_v),
    .f_i        (det_f),
    .lock_nxt_o (lock_nxt)
  );

  vid_trs_timing_out u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_mode_i (h_ref_mode_i),
    .lock_i     (lock_nxt),
    .tail_i     (tail),
    .y_o        (luma_o),
    .c_o        (chroma_o),
    .h_o        (h_o),
    .v_o        (v_o),
    .f_o        (f_o),
    .eav_o      (eav_o),
    .sav_o      (sav_o),
    .locked_o   (locked_o)
  );
endmodule

// File: rtl/vid_trs_timing_chk.sv
module vid_trs_timing_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic h_o,
  input logic v_o,
  input logic f_o,
  input logic eav_o,
  input logic sav_o,
  input logic locked_o
);
  assert_gate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_o |-> (!h_o && !v_o && !f_o));

  assert_pulse_excl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({eav_o, sav_o}));

  assert_pulse_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eav_o |=> !eav_o);

  // status words are always inside H in both styles (R6, R7)
  assert_h_on_xyz_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && (eav_o || sav_o)) |-> h_o);

  assert_vf_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && $past(locked_o) && !eav_o) |-> ($stable(v_o) && $stable(f_o)));

  assert_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> (!h_o && !v_o && !f_o));
endmodule

bind vid_trs_timing vid_trs_timing_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .h_o      (h_o),
  .v_o      (v_o),
  .f_o      (f_o),
  .eav_o    (eav_o),
  .sav_o    (sav_o),
  .locked_o (locked_o)
);

// File: tb/vid_trs_timing_tb.sv
`timescale 1ns/1ps
module vid_trs_timing_tb;
  localparam int U    = 30;
  localparam int NL   = 10;
  localparam int LAT  = 9;
  localparam int MAXN = 4096;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wide_i = 1'b1;
  logic       h_ref_mode_i = 1'b0;
  logic [9:0] luma_i = '0;
  logic [9:0] chroma_i = '0;
  logic [9:0] luma_o, chroma_o;
  logic       h_o, v_o, f_o, eav_o, sav_o, locked_o;

  int tests = 0;
  int fails = 0;
  int ecnt, scnt;
  logic [9:0] rec_y [MAXN];
  logic rec_h [MAXN];
  logic rec_v [MAXN];
  logic rec_f [MAXN];
  logic rec_e [MAXN];
  logic rec_s [MAXN];
  logic rec_l [MAXN];

  always #2 clk_i = ~clk_i;

  vid_trs_timing u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wide_i(wide_i), .h_ref_mode_i(h_ref_mode_i),
    .luma_i(luma_i), .chroma_i(chroma_i), .luma_o(luma_o), .chroma_o(chroma_o),
    .h_o(h_o), .v_o(v_o), .f_o(f_o), .eav_o(eav_o), .sav_o(sav_o), .locked_o(locked_o)
  );

  task automatic chk(input string req, input int act, input int exp, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [9:0] xyz(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
  endfunction

  function automatic logic vexp(input int fl);
    return (fl == 0 || fl == 1 || fl == 5 || fl == 6);
  endfunction

  function automatic logic fexp(input int fl);
    return fl >= 5;
  endfunction

  // line: EAV 0..3, blanking 4..9, SAV 10..13, active 14..U-1
  function automatic logic [9:0] gen(input int u, input bit is_c);
    int pos = u % U;
    int fl  = (u / U) % NL;
    if (pos == 0 || pos == 10) return 10'h3FF;
    if (pos == 1 || pos == 2 || pos == 11 || pos == 12) return 10'h000;
    if (pos == 3) return xyz(fexp(fl), vexp(fl), 1'b1);
    if (pos == 13) return xyz(fexp(fl), vexp(fl), 1'b0);
    if (pos < 10) return is_c ? 10'h200 : 10'h040;
    return is_c ? 10'h200 : 10'(10'h100 + pos);
  endfunction

  function automatic int xc(input bit w, input int u);
    return w ? u : 2 * u + 1;
  endfunction

  task automatic do_reset(input bit w, input bit refm);
    rst_ni = 1'b0;
    wide_i = w;
    h_ref_mode_i = refm;
    luma_i = 10'h040;
    chroma_i = 10'h200;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic put(input logic [9:0] y, input logic [9:0] c);
    @(negedge clk_i);
    if (eav_o) ecnt++;
    if (sav_o) scnt++;
    luma_i = y;
    chroma_i = c;
  endtask

  task automatic test_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R11", {h_o, v_o, f_o, locked_o, eav_o, sav_o}, 0, "outputs in reset");
    chk("R11", luma_o, 0, "luma_o in reset");
  endtask

  task automatic test_stream(input bit w, input bit refm);
    int cpu = w ? 1 : 2;
    int units_main = 4 * NL * U + 4;
    int lc = U * cpu;
    int total = units_main * cpu + 3 * lc;
    string rdet = w ? "R1" : "R3";
    string rh = refm ? "R7" : "R6";
    int x, x0, xe, bad;
    do_reset(w, refm);
    for (int n = 0; n < total; n++) begin
      int u = n / cpu;
      @(negedge clk_i);
      rec_y[n] = luma_o; rec_h[n] = h_o; rec_v[n] = v_o; rec_f[n] = f_o;
      rec_e[n] = eav_o;  rec_s[n] = sav_o; rec_l[n] = locked_o;
      if (u < units_main) begin
        luma_i = gen(u, 1'b0);
        chroma_i = w ? gen(u, 1'b1) : ((n % 3 == 0) ? 10'h3FF : 10'h000);
      end else begin
        luma_i = 10'h040;
        chroma_i = w ? 10'h200 : 10'h3FF;
      end
    end
    // detection before lock
    x = xc(w, U + 3);
    chk(rdet, rec_e[x+LAT], 1, "eav pulse on status word");
    chk(rdet, rec_e[x+LAT-1], 0, "no eav pulse before status word");
    x = xc(w, U + 13);
    chk(rdet, rec_s[x+LAT], 1, "sav pulse on status word");
    x = xc(w, 2 * U + 20);
    chk("R5", rec_y[x+LAT], gen(2 * U + 20, 1'b0), "luma_o delay");
    x = xc(w, 2 * U + 5);
    chk("R11", rec_h[x+LAT], 0, "h gated before lock");
    // lock at second frame start
    x0 = xc(w, 2 * NL * U + 3);
    chk("R9", rec_l[x0], 0, "locked before second frame start");
    chk("R9", rec_l[x0+1], 1, "locked after second frame start");
    // H shape over one locked line
    bad = 0;
    for (int pos = 0; pos < U; pos++) begin
      for (int k = 0; k < cpu; k++) begin
        int n = ((2 * NL + 3) * U + pos) * cpu + k;
        int eh = refm ? ((pos < 4 || (pos >= 10 && pos < 14)) ? 1 : 0) : (pos < 14 ? 1 : 0);
        if (rec_h[n+LAT] != 1'(eh)) bad++;
      end
    end
    chk(rh, bad, 0, "h mismatches over a line");
    // V and F update and hold
    bad = 0;
    for (int L = 2 * NL + 1; L < 4 * NL; L++) begin
      x = xc(w, L * U + 3);
      if (rec_v[x+LAT] != vexp(L % NL) || rec_f[x+LAT] != fexp(L % NL)) bad++;
      if (rec_v[x+LAT-1] != vexp((L - 1) % NL) || rec_f[x+LAT-1] != fexp((L - 1) % NL)) bad++;
    end
    chk("R8", bad, 0, "v/f mismatches at status words");
    // missing reference
    xe = xc(w, units_main - 1);
    chk("R10", rec_l[xe+lc], 1, "lock held up to expected eav");
    chk("R10", rec_v[xe+lc], 1, "v held before loss");
    chk("R10", rec_h[xe+lc], refm ? 0 : 1, "h before loss");
    chk("R10", rec_l[xe+lc+1], 0, "lock cleared on missing eav");
    chk("R10", {rec_h[xe+lc+1], rec_v[xe+lc+1], rec_f[xe+lc+1]}, 0, "timing cleared with lock");
  endtask

  task automatic test_reject_wide();
    logic [9:0] e = xyz(1'b0, 1'b0, 1'b1);
    do_reset(1'b1, 1'b0);
    ecnt = 0; scnt = 0;
    put(10'h3FF, 10'h3FF); put(0, 0); put(0, 0); put(e, e);
    repeat (6) put(10'h040, 10'h200);
    put(10'h3FF, 10'h3FF); put(0, 0); put(0, 0); put(e, e ^ 10'h004);
    repeat (6) put(10'h040, 10'h200);
    put(10'h3FF, 10'h3FF); put(0, 0); put(0, 10'h040); put(e, e);
    repeat (14) put(10'h040, 10'h200);
    chk("R2", ecnt, 1, "eav pulses with chroma disagreement");
    chk("R1", scnt, 0, "no sav pulses");
  endtask

  task automatic test_reject_mux();
    logic [9:0] s = xyz(1'b0, 1'b0, 1'b0);
    do_reset(1'b0, 1'b0);
    ecnt = 0; scnt = 0;
    put(10'h3FF, 10'h000); put(10'h3FF, 10'h3FF);
    repeat (4) put(0, 10'h3FF);
    put(s, 10'h3FF); put(s, 10'h000);
    repeat (6) put(10'h040, 10'h3FF);
    put(10'h3FF, 0); put(10'h3FF, 0);
    repeat (4) put(0, 0);
    put(s, 0); put(s ^ 10'h004, 0);
    repeat (6) put(10'h040, 10'h3FF);
    put(10'h3FF, 10'h3FF);
    repeat (4) put(0, 10'h3FF);
    put(s, 10'h3FF); put(s, 10'h3FF);
    repeat (14) put(10'h040, 10'h3FF);
    chk("R4", scnt, 1, "sav pulses with broken copies");
    chk("R3", ecnt, 0, "no eav pulses with chroma noise");
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    test_reset();
    test_stream(1'b1, 1'b0);
    test_stream(1'b1, 1'b1);
    test_stream(1'b0, 1'b0);
    test_reject_wide();
    test_reject_mux();
    summary();
  end
endmodule